// File: doc/BRIEF.md
# Per-Function Interrupt Mask Controller

This block keeps the mask state for message interrupts raised by up to 32 virtual functions toward their managing function. The mask bits live in two 32-bit registers that are laid out unevenly: functions 1 to 16 sit in a 16-bit field starting at bit 9 of the low register, and functions 17 to 32 sit at the bottom of the high register. A command port takes a 32-bit function mask and an opcode. An unmask opcode clears the selected bits, and a mask opcode sets them. Each register is read, modified and written back only when its own half of the request mask has at least one bit set.

Both registers are always visible on a read port. A 32-bit pending vector, one bit per function, is combined with the mask state into a single interrupt line. The line is high while any function is pending and not masked. A separate single mask register covers the opposite message direction. Software writes 0x0 to it to enable those messages and 0x2 to disable them, and the block brings the resulting enable out as a level.

Top module: `vfim_top`

## Requirements
- R1: Request mask bit k for k in 0..15 (function k+1) controls bit 9+k of `rd_lo`.
- R2: Request mask bit k for k in 16..31 (function k+1) controls bit k-16 of `rd_hi`.
- R3: A command with `cmd_op`=0 (unmask) clears every selected mask bit and leaves the unselected mask bits unchanged. The result is visible on the read port in the cycle after the clock edge that samples `cmd_valid`.
- R4: A command with `cmd_op`=1 (mask) sets every selected mask bit and leaves the unselected mask bits unchanged, with the same timing as R3.
- R5: A register whose 16-bit half of the request mask is all zero is left unchanged by the command.
- R6: Bits of `rd_lo` outside 24:9 and bits of `rd_hi` outside 15:0 read 0 and never change.
- R7: After reset every function is masked, so `rd_lo`=0x01FFFE00 and `rd_hi`=0x0000FFFF, and `irq_out` is 0 for any pending pattern.
- R8: `irq_out` is the OR over all functions of (`fn_pend` bit i AND NOT the mask bit of function i+1), evaluated combinationally from the current mask state.
- R9: The reverse-direction mask register resets to 0x2 and takes `pf_wdata` on the edge where `pf_wr` is high. `pf_msg_en` is 1 exactly when bit 1 of that register is 0, so writing 0x0 enables the direction and 0x2 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Mask update command strobe |
| cmd_op | input | 1 | 0 = unmask (clear bits), 1 = mask (set bits) |
| cmd_fmask | input | 32 | Function select, bit i = function i+1 |
| fn_pend | input | 32 | Pending message interrupt per function |
| rd_lo | output | 32 | Low mask register contents |
| rd_hi | output | 32 | High mask register contents |
| irq_out | output | 1 | Combined interrupt for unmasked pending functions |
| pf_wr | input | 1 | Write strobe for the reverse-direction mask register |
| pf_wdata | input | 32 | Write data for that register |
| pf_q | output | 32 | Current reverse-direction mask register value |
| pf_msg_en | output | 1 | Reverse-direction messages enabled |

## Verification
A wrong mask bit shows on `rd_lo` or `rd_hi` in the cycle after the command that produced it. It also changes `irq_out` as soon as a pending pattern touches that function, so the bench compares both read registers and the interrupt after every command against a model. Placement errors between the two halves show up as bits at the wrong offset on the same read. A write to the untouched half that does change state is caught at the first comparison that follows it.

// File: rtl/vfim_pkg.sv
package vfim_pkg;
   typedef enum logic {
      OP_UNMASK = 1'b0,
      OP_MASK   = 1'b1
   } mask_op_e;

   // Value that disables the reverse direction, and the bit it uses.
   localparam int unsigned PF_OFF_BIT = 1;
endpackage

// File: rtl/vfim_mask_half.sv
module vfim_mask_half #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned FLD_W   = 16,
   parameter int unsigned FLD_LSB = 0,
   parameter logic [REG_W-1:0] RST_OTHER = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  vfim_pkg::mask_op_e op,
   input  logic [FLD_W-1:0] sel,
   output logic [REG_W-1:0] q,
   output logic [FLD_W-1:0] fld
);
   localparam int unsigned FLD_MSB = FLD_LSB + FLD_W - 1;

   generate
      if (FLD_MSB >= REG_W) begin : g_bad_fit
         $error("mask field does not fit in register");
      end
   endgenerate

   logic             touch;
   logic [REG_W-1:0] q_nxt;

   // Read-modify-write only when this half is addressed at all.
   assign touch = cmd_valid && (|sel);

   genvar b;
   generate
      for (b = 0; b < REG_W; b++) begin : g_bit
         if (b >= FLD_LSB && b <= FLD_MSB) begin : g_fld
            always_comb begin
               q_nxt[b] = q[b];
               if (sel[b-FLD_LSB])
                  q_nxt[b] = (op == vfim_pkg::OP_MASK);
            end
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q[b] <= 1'b1;
               else if (touch)
                  q[b] <= q_nxt[b];
            end
         end else begin : g_keep
            assign q_nxt[b] = q[b];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q[b] <= RST_OTHER[b];
               else
                  q[b] <= q[b];
            end
         end
      end
   endgenerate

   assign fld = q[FLD_MSB:FLD_LSB];
endmodule

// File: rtl/vfim_irq_combine.sv
module vfim_irq_combine #(
   parameter int unsigned N       = 32,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend,
   input  logic [N-1:0] masked,
   output logic         irq
);
   logic [N-1:0] live;
   logic         any_live;

   assign live     = pend & ~masked;
   assign any_live = |live;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq <= 1'b0;
            else
               irq <= any_live;
         end
      end else begin : g_comb
         assign irq = any_live;
      end
   endgenerate
endmodule

// File: rtl/vfim_pf_reg.sv
module vfim_pf_reg #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned OFF_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q,
   output logic             en
);
   localparam logic [REG_W-1:0] RST_VAL = REG_W'(1) << OFF_BIT;

   generate
      if (OFF_BIT >= REG_W) begin : g_bad_bit
         $error("disable bit outside register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (wr)
         q <= wdata;
   end

   assign en = ~q[OFF_BIT];
endmodule

// File: rtl/vfim_top.sv
module vfim_top #(
   parameter int unsigned NUM_FN  = 32,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned LO_LSB  = 9,
   parameter int unsigned HI_LSB  = 0,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [NUM_FN-1:0] cmd_fmask,
   input  logic [NUM_FN-1:0] fn_pend,
   output logic [REG_W-1:0]  rd_lo,
   output logic [REG_W-1:0]  rd_hi,
   output logic              irq_out,
   input  logic              pf_wr,
   input  logic [REG_W-1:0]  pf_wdata,
   output logic [REG_W-1:0]  pf_q,
   output logic              pf_msg_en
);
   localparam int unsigned HALF = NUM_FN / 2;

   generate
      if (NUM_FN % 2 != 0) begin : g_bad_count
         $error("function count must be even");
      end
   endgenerate

   vfim_pkg::mask_op_e op;
   logic [HALF-1:0]    lo_fld;
   logic [HALF-1:0]    hi_fld;

   assign op = vfim_pkg::mask_op_e'(cmd_op);

   vfim_mask_half #(
      .REG_W(REG_W), .FLD_W(HALF), .FLD_LSB(LO_LSB), .RST_OTHER('0)
   ) i_lo (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op),
      .sel(cmd_fmask[HALF-1:0]), .q(rd_lo), .fld(lo_fld)
   );

   vfim_mask_half #(
      .REG_W(REG_W), .FLD_W(HALF), .FLD_LSB(HI_LSB), .RST_OTHER('0)
   ) i_hi (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op),
      .sel(cmd_fmask[NUM_FN-1:HALF]), .q(rd_hi), .fld(hi_fld)
   );

   vfim_irq_combine #(.N(NUM_FN), .REG_OUT(IRQ_REG)) i_irq (
      .clk(clk), .rst_n(rst_n), .pend(fn_pend),
      .masked({hi_fld, lo_fld}), .irq(irq_out)
   );

   vfim_pf_reg #(.REG_W(REG_W), .OFF_BIT(vfim_pkg::PF_OFF_BIT)) i_pf (
      .clk(clk), .rst_n(rst_n), .wr(pf_wr), .wdata(pf_wdata),
      .q(pf_q), .en(pf_msg_en)
   );
endmodule

// File: rtl/vfim_checker.sv
module vfim_checker #(
   parameter int unsigned NUM_FN  = 32,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned LO_LSB  = 9,
   parameter int unsigned HI_LSB  = 0,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_op,
   input logic [NUM_FN-1:0] cmd_fmask,
   input logic [NUM_FN-1:0] fn_pend,
   input logic [REG_W-1:0]  rd_lo,
   input logic [REG_W-1:0]  rd_hi,
   input logic              irq_out,
   input logic              pf_wr,
   input logic [REG_W-1:0]  pf_wdata,
   input logic [REG_W-1:0]  pf_q,
   input logic              pf_msg_en
);
   localparam int unsigned HALF = NUM_FN / 2;
   localparam logic [REG_W-1:0] LO_FLD_M = {{(REG_W-HALF){1'b0}}, {HALF{1'b1}}} << LO_LSB;
   localparam logic [REG_W-1:0] HI_FLD_M = {{(REG_W-HALF){1'b0}}, {HALF{1'b1}}} << HI_LSB;

   logic [HALF-1:0] lo_f, hi_f;
   assign lo_f = rd_lo[LO_LSB +: HALF];
   assign hi_f = rd_hi[HI_LSB +: HALF];

   // R5: an unaddressed half stays as it was
   a_r5_lo_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_fmask[HALF-1:0] == '0) |=> $stable(rd_lo));
   a_r5_hi_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_fmask[NUM_FN-1:HALF] == '0) |=> $stable(rd_hi));

   // R3: unmask clears the selected bits
   a_r3_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_op) |=>
      ((lo_f & $past(cmd_fmask[HALF-1:0])) == '0 &&
       (hi_f & $past(cmd_fmask[NUM_FN-1:HALF])) == '0));

   // R4: mask sets the selected bits
   a_r4_mask_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op) |=>
      ((lo_f & $past(cmd_fmask[HALF-1:0])) == $past(cmd_fmask[HALF-1:0]) &&
       (hi_f & $past(cmd_fmask[NUM_FN-1:HALF])) == $past(cmd_fmask[NUM_FN-1:HALF])));

   // R6: bits outside the fields never move
   a_r6_outside_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo & ~LO_FLD_M) == '0);
   a_r6_outside_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi & ~HI_FLD_M) == '0);

   // R9: enable level follows the stored register
   a_r9_pf_write: assert property (@(posedge clk) disable iff (!rst_n)
      pf_wr |=> (pf_q == $past(pf_wdata)));
   a_r9_pf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pf_wr |=> $stable(pf_q));

   // R8: no pending or everything masked means no interrupt
   generate
      if (!IRQ_REG) begin : g_comb_chk
         a_r8_quiet_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
            (fn_pend == '0) |-> !irq_out);
         a_r8_quiet_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
            ((&lo_f) && (&hi_f)) |-> !irq_out);
      end
   endgenerate
endmodule

bind vfim_top vfim_checker #(
   .NUM_FN(NUM_FN), .REG_W(REG_W), .LO_LSB(LO_LSB),
   .HI_LSB(HI_LSB), .IRQ_REG(IRQ_REG)
) i_chk (.*);

// File: tb/test_vfim_top.sv
module test_vfim_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic [31:0] cmd_fmask = '0;
   logic [31:0] fn_pend = '0;
   logic [31:0] rd_lo, rd_hi, pf_q;
   logic        irq_out, pf_msg_en;
   logic        pf_wr = 1'b0;
   logic [31:0] pf_wdata = '0;

   int checks = 0;
   int failures = 0;
   logic [15:0] m_lo, m_hi;
   logic [31:0] m_pf;
   int unsigned seed_dummy;

   always #10 clk = ~clk;

   vfim_top i_vfim_top (.*);

   function automatic logic [31:0] exp_lo(logic [15:0] f);
      return {7'b0, f, 9'b0};
   endfunction
   function automatic logic [31:0] exp_hi(logic [15:0] f);
      return {16'b0, f};
   endfunction
   function automatic logic exp_irq(logic [31:0] p, logic [15:0] lo, logic [15:0] hi);
      return |(p & ~{hi, lo});
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(logic op, logic [31:0] fm);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_fmask = fm;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (fm[15:0] != 0)
         for (int k = 0; k < 16; k++) if (fm[k]) m_lo[k] = op;
      if (fm[31:16] != 0)
         for (int k = 0; k < 16; k++) if (fm[16+k]) m_hi[k] = op;
   endtask

   task automatic chk_regs(string req);
      chk(req, rd_lo, exp_lo(m_lo));
      chk(req, rd_hi, exp_hi(m_hi));
   endtask

   task automatic chk_irq(string req, logic [31:0] p);
      fn_pend = p;
      #1;
      chk(req, {31'b0, irq_out}, {31'b0, exp_irq(p, m_lo, m_hi)});
   endtask

   task automatic pf_write(logic [31:0] v);
      @(negedge clk);
      pf_wr = 1'b1; pf_wdata = v;
      @(negedge clk);
      pf_wr = 1'b0;
      m_pf = v;
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_1234);
      m_lo = 16'hFFFF; m_hi = 16'hFFFF; m_pf = 32'h2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state
      chk("R7", rd_lo, 32'h01FF_FE00);
      chk("R7", rd_hi, 32'h0000_FFFF);
      chk_irq("R7", 32'hFFFF_FFFF);
      // R9: reset value and disabled level
      chk("R9", pf_q, 32'h2);
      chk("R9", {31'b0, pf_msg_en}, 32'h0);

      // R1: function 1 and function 16 edges of the low field
      send(1'b0, 32'h0000_8001);
      chk("R1", rd_lo, 32'h01FF_FE00 & ~32'h0100_0200);
      chk("R5", rd_hi, 32'h0000_FFFF);
      chk_irq("R8", 32'h0000_0001);
      chk_irq("R8", 32'h0000_0002);
      // R2: function 17 and function 32 edges of the high field
      send(1'b0, 32'h8001_0000);
      chk("R2", rd_hi, 32'h0000_7FFE);
      chk_irq("R8", 32'h8000_0000);
      // R4: mask re-sets, R5 low untouched
      send(1'b1, 32'h8000_0000);
      chk_regs("R4");
      chk_irq("R8", 32'h8000_0000);
      // R3: unmask everything then mask everything
      send(1'b0, 32'hFFFF_FFFF);
      chk_regs("R3");
      chk("R6", rd_lo & ~32'h01FF_FE00, 32'h0);
      chk_irq("R8", 32'h0010_0000);
      chk_irq("R8", 32'h0);
      send(1'b1, 32'hFFFF_FFFF);
      chk_regs("R4");
      chk_irq("R8", 32'hFFFF_FFFF);
      // R5: zero mask command changes nothing
      send(1'b0, 32'h0);
      chk_regs("R5");

      // R9: enable/disable of the reverse direction
      pf_write(32'h0);
      chk("R9", pf_q, 32'h0);
      chk("R9", {31'b0, pf_msg_en}, 32'h1);
      pf_write(32'h2);
      chk("R9", pf_q, 32'h2);
      chk("R9", {31'b0, pf_msg_en}, 32'h0);
      chk_regs("R9");

      // Random mix: R3 R4 R5 R6 R8
      for (int it = 0; it < 400; it++) begin
         logic [31:0] fm;
         logic [1:0]  kind;
         kind = 2'($urandom_range(0, 3));
         fm = $urandom;
         case (kind)
            2'd0: fm[31:16] = '0;
            2'd1: fm[15:0] = '0;
            2'd2: fm = fm & $urandom;
            default: ;
         endcase
         send(1'($urandom_range(0, 1)), fm);
         chk_regs(fm[31:16] == 0 || fm[15:0] == 0 ? "R5" : "R3");
         chk("R6", rd_hi & 32'hFFFF_0000, 32'h0);
         chk_irq("R8", $urandom & $urandom);
         if (it % 50 == 0) begin
            logic [31:0] v;
            v = $urandom;
            pf_write(v);
            chk("R9", pf_q, m_pf);
            chk("R9", {31'b0, pf_msg_en}, {31'b0, ~m_pf[1]});
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule